// File: doc/BRIEF.md
# NAND Flash Operation Engine

This block is the core of a NAND flash host controller. Software programs a small 16-bit register set and then starts a single primitive bus operation on an 8-bit NAND device. The primitives are: a command cycle, an address cycle, page data input (buffer to flash), page data output (flash to buffer), read ID and read status. Only one operation runs at a time. The block drives the command latch, address latch, chip enable, write strobe, read strobe and data pins, and it watches the ready/busy line. An operation does not finish until the device reports ready.

Page data passes through an internal byte buffer that the host also reaches through its own port. The buffer holds `AREAS` main areas of `MAIN_BYTES` each, followed by `AREAS` spare areas of `SPARE_BYTES` each. A single area register picks the main/spare pair that an operation uses. ID and status bytes are stored in that buffer, not in a register. When an operation completes it raises a sticky done flag. An interrupt line reports the flag unless it is masked.

The sequencer FSM has eight states:
- `S_IDLE`: no operation is running.
- `S_FETCH`: a buffer read is in flight, used for data input only.
- `S_SETUP`: the latch lines and data are set up, with both strobes high.
- `S_LO`: the active strobe is held low.
- `S_HI`: the strobe is back high.
- `S_ZERO`: the status high byte is cleared.
- `S_SETTLE`: a one-clock gap that lets the device pull busy.
- `S_WAITRB`: waiting for the device to report ready.

The transitions are:
- `S_IDLE` goes to `S_FETCH` on a data-input start, and to `S_SETUP` on any other start.
- `S_FETCH` goes to `S_SETUP`.
- `S_SETUP` goes to `S_LO`.
- `S_LO` goes to `S_HI` when its low timer expires.
- `S_HI` goes to the next byte's `S_FETCH` or `S_SETUP` when its timer expires and bytes remain.
- After the last byte, `S_HI` goes to `S_ZERO` for read status, or to `S_SETTLE` for every other operation.
- `S_ZERO` goes to `S_SETTLE`.
- `S_SETTLE` goes to `S_WAITRB`.
- `S_WAITRB` goes to `S_IDLE` once ready/busy reads high.

Top module: `nand_op_engine`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high, both latch lines are low, the data pins are not driven, the done flag is 0, the interrupt is low and the interrupt mask (configuration bit 4) is 1.
- R2: Writing 0x0001 to the operation-control register (address 4) produces exactly one write strobe with the command latch high, the address latch low, and the data pins carrying the low byte of the command register (address 0).
- R3: Writing 0x0002 produces exactly one write strobe with the address latch high, the command latch low, and the data pins carrying the low byte of the address register (address 1).
- R4: Writing 0x0004 (data input) sends, one byte per write strobe, the 512 bytes at buffer offset 0x200*k followed by the 16 bytes at 0x800+0x10*k, where k is the area register (address 2). When configuration bit 2 (spare-only, address 3) is set, only the 16 spare bytes are sent.
- R5: Writing 0x0008 (data output) issues one read strobe per byte and stores the bytes using the same layout as R4, including the spare-only variant. Buffer bytes outside the target range are left unchanged.
- R6: Writing 0x0010 (read ID) issues ID_BYTES read strobes and stores the bytes from offset 0x200*k onward, whatever the spare-only bit holds.
- R7: Writing 0x0020 (read status) issues one read strobe, stores the byte at offset 0x200*k, and writes 0 to offset 0x200*k+1.
- R8: Bit 15 of the operation-control register is set only after the device's ready/busy line is seen high at the end of an operation. It then stays set until software writes the operation-control register with bit 15 = 0 and no start bit. Writing bit 15 = 1 leaves it set.
- R9: The interrupt output is high exactly when the done flag is 1 and configuration bit 4 is 0.
- R10: A write to the operation-control register while an operation runs has no effect. A write whose bits 5:0 are not one-hot starts nothing.
- R11: Each strobe stays low for exactly STROBE_LO clocks. The latch lines are unchanged during the clock before every strobe falls. Write and read strobes are never low together, and no strobe falls while chip enable is high.
- R12: Reading the operation-control register returns the done flag in bit 15 and the running operation's one-hot code in bits 5:0. Bits 5:0 read 0 when the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 cmd, 1 addr, 2 area, 3 config, 4 op-control) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | 12 | Host buffer byte address |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Host buffer read byte, one clock after the address |
| irq | output | 1 | Completion interrupt |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Data driven to the device |
| nand_io_oe | output | 1 | Data output enable |
| nand_io_in | input | 8 | Data from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong byte counter or a wrong area base appears as a byte sequence on the pins that is shifted, too short or too long, or as data landing at the wrong buffer offset. Each of these is caught at the end of the transfer, when the flash model's queues and the host readback are compared. A corrupted strobe timer, or a latch line that changes without a setup clock, is reported on the very clock of the faulty strobe edge. A done flag that ignores ready/busy, or an operation-control register that accepts writes while busy, shows up within a few clocks as an early done bit, a lost done bit, or an extra command strobe.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

    localparam int REG_AW = 3;
    localparam int OP_W   = 6;

    localparam logic [REG_AW-1:0] RA_CMD   = 3'd0;
    localparam logic [REG_AW-1:0] RA_ADDR  = 3'd1;
    localparam logic [REG_AW-1:0] RA_AREA  = 3'd2;
    localparam logic [REG_AW-1:0] RA_CFG   = 3'd3;
    localparam logic [REG_AW-1:0] RA_OPCTL = 3'd4;

    typedef enum logic [2:0] {
        K_CMD, K_ADDR, K_DIN, K_DOUT, K_ID, K_STAT
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_SETUP, S_LO, S_HI, S_ZERO, S_SETTLE, S_WAITRB
    } seq_state_e;

    function automatic op_kind_e kind_of(input logic [OP_W-1:0] code);
        op_kind_e k;
        unique case (code)
            6'b000001: k = K_CMD;
            6'b000010: k = K_ADDR;
            6'b000100: k = K_DIN;
            6'b001000: k = K_DOUT;
            6'b010000: k = K_ID;
            6'b100000: k = K_STAT;
            default:   k = K_CMD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nand_buf_ram.sv
module nand_buf_ram #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    // Engine port (b) is written last, so it wins on a same-address clash.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/nand_regfile.sv
module nand_regfile
    import nand_eng_pkg::*;
#(
    parameter int AREA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              busy,
    input  logic              fin,
    output logic              start,
    output logic [OP_W-1:0]   start_op,
    output logic [7:0]        cmd_byte,
    output logic [7:0]        addr_byte,
    output logic [AREA_W-1:0] area,
    output logic              spare_only,
    output logic              done,
    output logic              irq
);
    logic              int_mask;
    logic [OP_W-1:0]   cur_op;
    logic              opctl_wr;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[14:8];
    assign opctl_wr = reg_we && (reg_addr == RA_OPCTL) && !busy;
    assign start    = opctl_wr && $onehot(reg_wdata[OP_W-1:0]);
    assign start_op = reg_wdata[OP_W-1:0];
    assign irq      = done && !int_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_byte   <= '0;
            addr_byte  <= '0;
            area       <= '0;
            spare_only <= 1'b0;
            int_mask   <= 1'b1;
            done       <= 1'b0;
            cur_op     <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    RA_CMD:  cmd_byte  <= reg_wdata[7:0];
                    RA_ADDR: addr_byte <= reg_wdata[7:0];
                    RA_AREA: area      <= reg_wdata[AREA_W-1:0];
                    RA_CFG: begin
                        spare_only <= reg_wdata[2];
                        int_mask   <= reg_wdata[4];
                    end
                    default: ;
                endcase
            end
            if (start) begin
                done   <= 1'b0;
                cur_op <= reg_wdata[OP_W-1:0];
            end else if (opctl_wr && !reg_wdata[15]) begin
                done <= 1'b0;
            end
            if (fin) begin
                done   <= 1'b1;
                cur_op <= '0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CMD:   reg_rdata = {8'h00, cmd_byte};
            RA_ADDR:  reg_rdata = {8'h00, addr_byte};
            RA_AREA:  reg_rdata = 16'(area);
            RA_CFG:   reg_rdata = {11'd0, int_mask, 1'b0, spare_only, 2'b00};
            RA_OPCTL: reg_rdata = {done, 9'd0, cur_op};
            default:  reg_rdata = 16'h0000;
        endcase
    end

    // R10: the running code is frozen until the operation finishes
    a_r10_busy_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(cur_op));
    // R12: a running operation always reports a one-hot code
    a_r12_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $onehot(cur_op));
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_eng_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int AREAS       = 4,
    parameter int ID_BYTES    = 5,
    parameter int STROBE_LO   = 2,
    parameter int STROBE_HI   = 1,
    parameter int AREA_W      = 2,
    parameter int AW          = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   start_op,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        addr_byte,
    input  logic [AREA_W-1:0] area,
    input  logic              spare_only,
    input  logic              rb_n,
    input  logic [7:0]        io_in,
    input  logic [7:0]        ram_q,
    output logic              busy,
    output logic              fin,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        io_out,
    output logic              io_oe,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata
);
    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
    localparam int SPARE_BASE = AREAS * MAIN_BYTES;
    localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
    localparam int TMAX       = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
    localparam int TMR_W      = $clog2(TMAX + 1);

    seq_state_e        state, nstate;
    op_kind_e          kind_q, start_kind;
    logic [AREA_W-1:0] area_q;
    logic              spare_q;
    logic [CNT_W-1:0]  cnt, total_q;
    logic [TMR_W-1:0]  tmr;
    logic [7:0]        io_reg;
    logic              last_byte, write_kind, strobe_phase;

    assign start_kind = kind_of(start_op);
    assign last_byte  = (int'(cnt) == int'(total_q) - 1);
    assign write_kind = (kind_q == K_CMD) || (kind_q == K_ADDR) || (kind_q == K_DIN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (start) nstate = (start_kind == K_DIN) ? S_FETCH : S_SETUP;
            S_FETCH:  nstate = S_SETUP;
            S_SETUP:  nstate = S_LO;
            S_LO:     if (tmr == '0) nstate = S_HI;
            S_HI: begin
                if (tmr == '0) begin
                    if (last_byte)              nstate = (kind_q == K_STAT) ? S_ZERO : S_SETTLE;
                    else if (kind_q == K_DIN)   nstate = S_FETCH;
                    else                        nstate = S_SETUP;
                end
            end
            S_ZERO:   nstate = S_SETTLE;
            S_SETTLE: nstate = S_WAITRB;
            S_WAITRB: if (rb_n) nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    // datapath: operands, byte counter, strobe timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_CMD;
            area_q  <= '0;
            spare_q <= 1'b0;
            cnt     <= '0;
            total_q <= CNT_W'(1);
            tmr     <= '0;
            io_reg  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    kind_q  <= start_kind;
                    area_q  <= area;
                    spare_q <= spare_only;
                    cnt     <= '0;
                    unique case (start_kind)
                        K_DIN, K_DOUT: total_q <= spare_only ? CNT_W'(SPARE_BYTES) : CNT_W'(PAGE_BYTES);
                        K_ID:          total_q <= CNT_W'(ID_BYTES);
                        default:       total_q <= CNT_W'(1);
                    endcase
                    if (start_kind == K_CMD)  io_reg <= cmd_byte;
                    if (start_kind == K_ADDR) io_reg <= addr_byte;
                end
                S_SETUP: begin
                    tmr <= TMR_W'(STROBE_LO - 1);
                    if (kind_q == K_DIN) io_reg <= ram_q;
                end
                S_LO: begin
                    if (tmr != '0) tmr <= tmr - TMR_W'(1);
                    else           tmr <= TMR_W'(STROBE_HI - 1);
                end
                S_HI: begin
                    if (tmr != '0)       tmr <= tmr - TMR_W'(1);
                    else if (!last_byte) cnt <= cnt + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // buffer address for the current byte
    always_comb begin
        int mb, sb, idx, a;
        mb  = int'(area_q) * MAIN_BYTES;
        sb  = SPARE_BASE + int'(area_q) * SPARE_BYTES;
        idx = int'(cnt);
        if (state == S_ZERO)                          a = mb + 1;
        else if (kind_q == K_ID || kind_q == K_STAT)  a = mb + idx;
        else if (spare_q)                             a = sb + idx;
        else if (idx < MAIN_BYTES)                    a = mb + idx;
        else                                          a = sb + idx - MAIN_BYTES;
        ram_addr = AW'(a);
    end

    // outputs
    always_comb begin
        busy         = (state != S_IDLE);
        strobe_phase = (state == S_SETUP) || (state == S_LO) || (state == S_HI);
        ce_n         = !busy;
        cle          = strobe_phase && (kind_q == K_CMD);
        ale          = strobe_phase && (kind_q == K_ADDR);
        we_n         = !((state == S_LO) && write_kind);
        re_n         = !((state == S_LO) && !write_kind);
        io_out       = io_reg;
        io_oe        = busy && write_kind;
        ram_we       = ((state == S_LO) && (tmr == '0) && !write_kind) || (state == S_ZERO);
        ram_wdata    = (state == S_ZERO) ? 8'h00 : io_in;
        fin          = (state == S_WAITRB) && rb_n;
    end

    // R11: latch lines and chip enable settle a clock before any strobe falls
    a_r11_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) || $fell(re_n)) |-> ($stable(cle) && $stable(ale) && $past(!ce_n)));
    // R11: the two latch lines never rise together
    a_r11_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R7: the status high byte is cleared right after the status strobe
    a_r7_zero_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ZERO) |-> ($past(state == S_HI) && kind_q == K_STAT));
    // R5: the buffer is written by the engine only on read-type operations
    a_r5_write_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !io_oe);
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
    import nand_eng_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int AREAS       = 4,
    parameter int ID_BYTES    = 5,
    parameter int STROBE_LO   = 2,
    parameter int STROBE_HI   = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        buf_we,
    input  logic [$clog2(AREAS*(MAIN_BYTES+SPARE_BYTES))-1:0] buf_addr,
    input  logic [7:0]  buf_wdata,
    output logic [7:0]  buf_rdata,
    output logic        irq,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rb_n
);
    localparam int DEPTH  = AREAS * (MAIN_BYTES + SPARE_BYTES);
    localparam int AW     = $clog2(DEPTH);
    localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1;

    logic              busy, fin, start, spare_only, done;
    logic [OP_W-1:0]   start_op;
    logic [7:0]        cmd_byte, addr_byte, ram_q, ram_wdata;
    logic [AREA_W-1:0] area;
    logic [AW-1:0]     ram_addr;
    logic              ram_we;

    nand_regfile #(.AREA_W(AREA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .fin(fin),
        .start(start), .start_op(start_op), .cmd_byte(cmd_byte),
        .addr_byte(addr_byte), .area(area), .spare_only(spare_only),
        .done(done), .irq(irq)
    );

    nand_seq #(
        .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .AREAS(AREAS),
        .ID_BYTES(ID_BYTES), .STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI),
        .AREA_W(AREA_W), .AW(AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .cmd_byte(cmd_byte), .addr_byte(addr_byte), .area(area),
        .spare_only(spare_only), .rb_n(nand_rb_n), .io_in(nand_io_in),
        .ram_q(ram_q), .busy(busy), .fin(fin), .ce_n(nand_ce_n),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .io_out(nand_io_out), .io_oe(nand_io_oe), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata)
    );

    nand_buf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk),
        .a_addr(buf_addr), .a_we(buf_we), .a_wdata(buf_wdata), .a_rdata(buf_rdata),
        .b_addr(ram_addr), .b_we(ram_we), .b_wdata(ram_wdata), .b_rdata(ram_q)
    );

    // R8: done rises only after the device was seen ready
    a_r8_ready_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(nand_rb_n));
    // R11: strobes only while the chip is enabled, never both at once
    a_r11_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> (!nand_ce_n && (nand_we_n || nand_re_n)));
endmodule

// File: tb/nand_op_engine_test.sv
module nand_op_engine_test;
    import nand_eng_pkg::*;

    localparam int MAIN  = 512;
    localparam int SPARE = 16;
    localparam int NAREA = 4;
    localparam int IDN   = 5;
    localparam int SLO   = 2;
    localparam int SHI   = 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        buf_we;
    logic [11:0] buf_addr;
    logic [7:0]  buf_wdata, buf_rdata;
    logic        irq, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb_n;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    nand_op_engine #(.MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .AREAS(NAREA),
                     .ID_BYTES(IDN), .STROBE_LO(SLO), .STROBE_HI(SHI)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural flash model and per-clock pin checks
    logic [7:0] cmdq[$], adrq[$], datq[$], rdq[$];
    logic p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0;
    int   lo_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(nand_we_n || nand_re_n, "R11 both strobes low", 0, 1);
            chk(!(nand_cle && nand_ale), "R11 both latches high", 1, 0);
            if (!nand_we_n || !nand_re_n) begin
                lo_len++;
                chk(!nand_ce_n, "R11 strobe with ce high", nand_ce_n, 0);
            end
            if ((p_we && !nand_we_n) || (p_re && !nand_re_n))
                chk(nand_cle == p_cle && nand_ale == p_ale, "R11 latch setup",
                    {nand_cle, nand_ale}, {p_cle, p_ale});
            if ((!p_we && nand_we_n) || (!p_re && nand_re_n)) begin
                chk(lo_len == SLO, "R11 strobe low width", lo_len, SLO);
                lo_len = 0;
            end
            if (!p_we && nand_we_n) begin
                if (nand_cle)      cmdq.push_back(nand_io_out);
                else if (nand_ale) adrq.push_back(nand_io_out);
                else               datq.push_back(nand_io_out);
            end
            if (p_re && !nand_re_n)
                nand_io_in = (rdq.size() > 0) ? rdq.pop_front() : 8'hEE;
        end
        p_we  = nand_we_n;
        p_re  = nand_re_n;
        p_cle = nand_cle;
        p_ale = nand_ale;
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = RA_OPCTL;
    endtask

    task automatic buf_write(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 12'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic buf_read(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = 12'(a);
        @(negedge clk);
        d = buf_rdata;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!reg_rdata[15] && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(reg_rdata[15], req, 0, 1);
    endtask

    task automatic run_all();
        logic [7:0] b;
        int ncmd, nadr;
        // R1 reset state
        rst_n = 1'b0; nand_rb_n = 1'b1; reg_we = 1'b0; buf_we = 1'b0;
        reg_addr = RA_OPCTL; reg_wdata = '0; buf_addr = '0; buf_wdata = '0; nand_io_in = '0;
        repeat (3) @(negedge clk);
        chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe} == 6'b111000,
            "R1 pins at reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 6'b111000);
        chk(reg_rdata == 16'h0000, "R1 op-control at reset", reg_rdata, 0);
        chk(irq == 1'b0, "R1 irq at reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_addr = RA_CFG;
        @(negedge clk);
        chk(reg_rdata[4] == 1'b1, "R1 mask set at reset", reg_rdata[4], 1);
        reg_addr = RA_OPCTL;

        // R2 command cycle, R8/R9 done and irq
        reg_write(RA_CMD, 16'h0070);
        reg_write(RA_OPCTL, 16'h0001);
        wait_done("R8 done after command");
        chk(cmdq.size() == 1 && cmdq[0] == 8'h70, "R2 command byte", cmdq.size() > 0 ? cmdq[0] : -1, 8'h70);
        chk(adrq.size() == 0 && datq.size() == 0, "R2 no other strobes", adrq.size() + datq.size(), 0);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        reg_write(RA_CFG, 16'h0000);
        chk(irq == 1'b1, "R9 irq unmasked", irq, 1);
        reg_write(RA_OPCTL, 16'h8000);
        chk(reg_rdata[15] == 1'b1, "R8 done kept on write of 1", reg_rdata[15], 1);
        reg_write(RA_OPCTL, 16'h0000);
        chk(reg_rdata[15] == 1'b0 && irq == 1'b0, "R8 done cleared", reg_rdata[15], 0);

        // R3 address cycle
        reg_write(RA_ADDR, 16'h00A5);
        reg_write(RA_OPCTL, 16'h0002);
        wait_done("R8 done after address");
        chk(adrq.size() == 1 && adrq[0] == 8'hA5, "R3 address byte", adrq.size() > 0 ? adrq[0] : -1, 8'hA5);
        chk(cmdq.size() == 1, "R3 no command strobe", cmdq.size(), 1);

        // R8 waits for ready
        nand_rb_n = 1'b0;
        reg_write(RA_CMD, 16'h00FF);
        reg_write(RA_OPCTL, 16'h0001);
        repeat (40) @(negedge clk);
        chk(reg_rdata[15] == 1'b0, "R8 done held while busy", reg_rdata[15], 0);
        nand_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(reg_rdata[15] == 1'b1, "R8 done after ready", reg_rdata[15], 1);

        // R5 data output, full page into area 2; R10 busy write ignored; R12 readback
        for (int i = 0; i < MAIN + SPARE; i++) rdq.push_back(8'((i * 13 + 7) & 255));
        ncmd = cmdq.size();
        reg_write(RA_AREA, 16'h0002);
        reg_write(RA_OPCTL, 16'h0008);
        reg_write(RA_OPCTL, 16'h0001);
        chk(reg_rdata[5:0] == 6'h08 && reg_rdata[15] == 1'b0, "R12 running code", reg_rdata, 16'h0008);
        wait_done("R8 done after data output");
        chk(cmdq.size() == ncmd, "R10 busy write ignored", cmdq.size(), ncmd);
        chk(rdq.size() == 0, "R5 strobe count", rdq.size(), 0);
        chk(reg_rdata[5:0] == 6'h00, "R12 idle code", reg_rdata[5:0], 0);
        for (int i = 0; i < MAIN; i++) begin
            buf_read(2 * MAIN + i, b);
            chk(b == 8'((i * 13 + 7) & 255), "R5 main byte", b, (i * 13 + 7) & 255);
        end
        for (int j = 0; j < SPARE; j++) begin
            buf_read(NAREA * MAIN + 2 * SPARE + j, b);
            chk(b == 8'(((MAIN + j) * 13 + 7) & 255), "R5 spare byte", b, ((MAIN + j) * 13 + 7) & 255);
        end

        // R10 non-one-hot code starts nothing
        ncmd = cmdq.size(); nadr = adrq.size();
        reg_write(RA_OPCTL, 16'h0003);
        repeat (10) @(negedge clk);
        chk(nand_ce_n == 1'b1 && reg_rdata[5:0] == 6'h00, "R10 bad code idle", reg_rdata[5:0], 0);
        chk(cmdq.size() == ncmd && adrq.size() == nadr, "R10 bad code no strobe", cmdq.size(), ncmd);

        // R4 data input, full page from area 1
        for (int i = 0; i < MAIN; i++) buf_write(MAIN + i, 8'((i * 5 + 1) & 255));
        for (int j = 0; j < SPARE; j++) buf_write(NAREA * MAIN + SPARE + j, 8'(8'hC0 + j));
        datq.delete();
        reg_write(RA_AREA, 16'h0001);
        reg_write(RA_OPCTL, 16'h0004);
        wait_done("R8 done after data input");
        chk(irq == 1'b1, "R9 irq on done", irq, 1);
        chk(datq.size() == MAIN + SPARE, "R4 byte count", datq.size(), MAIN + SPARE);
        if (datq.size() == MAIN + SPARE) begin
            for (int i = 0; i < MAIN; i++)
                chk(datq[i] == 8'((i * 5 + 1) & 255), "R4 main byte", datq[i], (i * 5 + 1) & 255);
            for (int j = 0; j < SPARE; j++)
                chk(datq[MAIN + j] == 8'(8'hC0 + j), "R4 spare byte", datq[MAIN + j], 8'hC0 + j);
        end

        // R4 spare-only input from area 3
        reg_write(RA_CFG, 16'h0004);
        for (int j = 0; j < SPARE; j++) buf_write(NAREA * MAIN + 3 * SPARE + j, 8'(8'h30 + j));
        datq.delete();
        reg_write(RA_AREA, 16'h0003);
        reg_write(RA_OPCTL, 16'h0004);
        wait_done("R8 done after spare input");
        chk(datq.size() == SPARE, "R4 spare-only count", datq.size(), SPARE);
        if (datq.size() == SPARE)
            for (int j = 0; j < SPARE; j++)
                chk(datq[j] == 8'(8'h30 + j), "R4 spare-only byte", datq[j], 8'h30 + j);

        // R5 spare-only output into area 0, main untouched
        buf_write(0, 8'h5A);
        for (int j = 0; j < SPARE; j++) rdq.push_back(8'(8'h90 + j));
        reg_write(RA_AREA, 16'h0000);
        reg_write(RA_OPCTL, 16'h0008);
        wait_done("R8 done after spare output");
        for (int j = 0; j < SPARE; j++) begin
            buf_read(NAREA * MAIN + j, b);
            chk(b == 8'(8'h90 + j), "R5 spare-only byte", b, 8'h90 + j);
        end
        buf_read(0, b);
        chk(b == 8'h5A, "R5 main untouched", b, 8'h5A);

        // R6 read ID into main area 1 despite spare-only
        rdq.push_back(8'hEC); rdq.push_back(8'hF1); rdq.push_back(8'h00);
        rdq.push_back(8'h95); rdq.push_back(8'h40);
        reg_write(RA_AREA, 16'h0001);
        reg_write(RA_OPCTL, 16'h0010);
        wait_done("R8 done after read ID");
        chk(rdq.size() == 0, "R6 strobe count", rdq.size(), 0);
        buf_read(MAIN + 0, b); chk(b == 8'hEC, "R6 id byte 0", b, 8'hEC);
        buf_read(MAIN + 1, b); chk(b == 8'hF1, "R6 id byte 1", b, 8'hF1);
        buf_read(MAIN + 3, b); chk(b == 8'h95, "R6 id byte 3", b, 8'h95);
        buf_read(MAIN + 4, b); chk(b == 8'h40, "R6 id byte 4", b, 8'h40);
        buf_read(MAIN + 5, b); chk(b == 8'((5 * 5 + 1) & 255), "R6 beyond id", b, 26);
        buf_read(NAREA * MAIN + SPARE, b); chk(b == 8'hC0, "R6 spare untouched", b, 8'hC0);

        // R7 read status into area 3
        buf_write(3 * MAIN + 1, 8'h77);
        rdq.push_back(8'hE0);
        reg_write(RA_AREA, 16'h0003);
        reg_write(RA_OPCTL, 16'h0020);
        wait_done("R8 done after status");
        buf_read(3 * MAIN, b);     chk(b == 8'hE0, "R7 status low byte", b, 8'hE0);
        buf_read(3 * MAIN + 1, b); chk(b == 8'h00, "R7 status high byte", b, 0);
    endtask

    initial begin
        bit wd = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule